// File: doc/BRIEF.md
# Rotating-Parity Block Array Controller

This block sits between a host that reads and writes single fixed-size blocks by logical block number and an array of `NDATA + 1` member stores. Each member is a word-addressed memory port with one row per stripe and a read response one cycle after the request. Every stripe row holds `NDATA` data blocks and one parity block, and the member that carries the parity moves from one stripe to the next, so the parity load is shared by every member.

A host read touches only the member that holds the block. A host write updates parity incrementally: it reads the old data and the old parity, then writes the new data and the new parity, which is the XOR of those three words. When a member is flagged as failed, reads aimed at it are rebuilt from the same row on every survivor, writes aimed at it fold the new word into the parity alone, and writes whose parity member is failed store only the data.

The host side uses a valid/ready handshake with one request in flight. A one-cycle `done` pulse returns the read word, or acknowledges a write, once the last member access has finished.

Top module: `stripe_parity_ctrl`

## Requirements
- R1: For logical block L, with stripe s = L / NDATA and slot k = L mod NDATA, the row is s, the parity member is p = NDATA - (s mod (NDATA+1)), and the data member is k when k < p, otherwise k+1.
- R2: A read of a block whose member is not failed issues exactly one member request, a read of that member at row s, and returns the stored word on `done_rdata` with `done` high in the third cycle after the accepting edge.
- R3: A write with no failed member involved makes exactly four member accesses: reads of the data and parity members in the first cycle after acceptance, writes of both in the third cycle. No read is issued after a write of the same operation, and `done` is high in the fourth cycle.
- R4: The new parity word written equals old parity XOR old data XOR new data, so every stripe's parity equals the XOR of its data blocks after each operation.
- R5: While `fail_en` is high, the member numbered `fail_id` receives no request. A read aimed at it returns the XOR of the same row on all other members and completes in the same cycle count as R2.
- R6: A write aimed at a failed data member reads the other data members of the stripe (neither the target nor parity), then writes only the parity member with the new word XOR those reads; `done` follows R3 timing.
- R7: A write whose stripe's parity member is failed issues no reads and writes only the data member, in the first cycle after acceptance; `done` is high in the second cycle.
- R8: After reset `host_ready` is 1, `done` is 0 and no member request is active. `host_ready` is high only while idle, no member request is active while `host_ready` is high, and `done` is a single-cycle pulse during which `host_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_en | input | 1 | A member is marked failed; hold stable while a request is in flight |
| fail_id | input | MW | Index of the failed member |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Controller idle and accepting a request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_lbn | input | LBN_W | Logical block number, below NDATA*ROWS |
| host_wdata | input | DW | Write word |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DW | Read result, valid with `done` for reads |
| mem_req | output | NM | Per-member request |
| mem_we | output | NM | Per-member write enable, qualified by `mem_req` |
| mem_addr | output | NM*AW | Per-member row address, member m at bits [m*AW +: AW] |
| mem_wdata | output | NM*DW | Per-member write word, member m at bits [m*DW +: DW] |
| mem_rdata | input | NM*DW | Per-member read word, valid the cycle after a read request |

## Verification
Counting from the edge that accepts a request, `done` is due in the second cycle for a write whose parity member is failed, the third for any read, and the fourth for other writes; member reads fall in the first cycle and member writes in the third (first for the parity-failed case). The bench samples at each falling edge after acceptance, counts them until `done` appears, and compares that count with the expected latency for the operation class. Member accesses are tallied by a bench memory model per operation and compared as read and write member masks, and after every operation each stripe's parity and every surviving data block are compared against a shadow copy of the logical contents.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RDREQ,
      ST_RDWAIT,
      ST_WRITE,
      ST_DONE
   } psc_state_e;
endpackage

// File: rtl/psc_stripe_map.sv
module psc_stripe_map #(
   parameter int NDATA = 3,
   parameter int LBN_W = 4,
   parameter int AW    = 2,
   parameter int MW    = 2
) (
   input  logic [LBN_W-1:0] lbn,
   output logic [AW-1:0]    row,
   output logic [MW-1:0]    dmem,
   output logic [MW-1:0]    pmem
);
   localparam int NM = NDATA + 1;

   logic [LBN_W-1:0] stripe_w, slot_w, rot_w;

   // R1: block to stripe row, parity member and data member
   always_comb begin
      stripe_w = lbn / LBN_W'(NDATA);
      slot_w   = lbn % LBN_W'(NDATA);
      rot_w    = stripe_w % LBN_W'(NM);
      row      = AW'(stripe_w);
      pmem     = MW'(NDATA) - MW'(rot_w);
      dmem     = (MW'(slot_w) < pmem) ? MW'(slot_w) : MW'(slot_w) + MW'(1);
   end
endmodule

// File: rtl/psc_xor_fold.sv
module psc_xor_fold #(
   parameter int NM = 4,
   parameter int DW = 8
) (
   input  logic [NM-1:0]    sel,
   input  logic [NM*DW-1:0] words,
   output logic [DW-1:0]    folded
);
   always_comb begin
      folded = '0;
      for (int m = 0; m < NM; m++) begin
         if (sel[m]) folded = folded ^ words[m*DW +: DW];
      end
   end
endmodule

// File: rtl/stripe_parity_ctrl.sv
module stripe_parity_ctrl #(
   parameter  int NDATA = 3,
   parameter  int DW    = 8,
   parameter  int ROWS  = 4,
   localparam int NM    = NDATA + 1,
   localparam int AW    = $clog2(ROWS),
   localparam int MW    = $clog2(NM),
   localparam int LBN_W = $clog2(NDATA * ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fail_en,
   input  logic [MW-1:0]    fail_id,
   input  logic             host_valid,
   output logic             host_ready,
   input  logic             host_we,
   input  logic [LBN_W-1:0] host_lbn,
   input  logic [DW-1:0]    host_wdata,
   output logic             done,
   output logic [DW-1:0]    done_rdata,
   output logic [NM-1:0]    mem_req,
   output logic [NM-1:0]    mem_we,
   output logic [NM*AW-1:0] mem_addr,
   output logic [NM*DW-1:0] mem_wdata,
   input  logic [NM*DW-1:0] mem_rdata
);
   import psc_pkg::*;

   if (NDATA < 2) begin : g_bad_ndata
      $error("stripe_parity_ctrl: NDATA must be at least 2");
   end
   if (ROWS < 2) begin : g_bad_rows
      $error("stripe_parity_ctrl: ROWS must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("stripe_parity_ctrl: DW must be positive");
   end

   psc_state_e        st_q, st_d;
   logic              wdat_en_q, wpar_en_q, wdat_en_d, wpar_en_d;
   logic [AW-1:0]     row_q, map_row;
   logic [MW-1:0]     dmem_q, pmem_q, map_dmem, map_pmem;
   logic [DW-1:0]     wdata_q, acc_q, fold_w;
   logic [NM-1:0]     rd_mask_q, rd_mask_d;
   logic [NM-1:0]     fmask, dmask, pmask;
   logic              op_we_q, accept;

   psc_stripe_map #(
      .NDATA (NDATA),
      .LBN_W (LBN_W),
      .AW    (AW),
      .MW    (MW)
   ) map_i (
      .lbn  (host_lbn),
      .row  (map_row),
      .dmem (map_dmem),
      .pmem (map_pmem)
   );

   psc_xor_fold #(
      .NM (NM),
      .DW (DW)
   ) fold_i (
      .sel    (rd_mask_q),
      .words  (mem_rdata),
      .folded (fold_w)
   );

   assign host_ready = (st_q == ST_IDLE);
   assign accept     = host_valid & host_ready;
   assign done       = (st_q == ST_DONE);
   assign done_rdata = acc_q;

   // plan of the member accesses for an incoming request
   always_comb begin
      fmask     = fail_en ? (NM'(1) << fail_id) : '0;
      dmask     = NM'(1) << map_dmem;
      pmask     = NM'(1) << map_pmem;
      rd_mask_d = '0;
      wdat_en_d = 1'b0;
      wpar_en_d = 1'b0;
      st_d      = ST_RDREQ;
      if (!host_we) begin
         rd_mask_d = ((dmask & fmask) != '0) ? ~fmask : dmask;           // R2 / R5
      end else if ((pmask & fmask) != '0) begin
         wdat_en_d = 1'b1;                                               // R7
         st_d      = ST_WRITE;
      end else if ((dmask & fmask) != '0) begin
         rd_mask_d = ~(dmask | pmask);                                   // R6
         wpar_en_d = 1'b1;
      end else begin
         rd_mask_d = dmask | pmask;                                      // R3
         wdat_en_d = 1'b1;
         wpar_en_d = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         op_we_q   <= 1'b0;
         wdat_en_q <= 1'b0;
         wpar_en_q <= 1'b0;
         row_q     <= '0;
         dmem_q    <= '0;
         pmem_q    <= '0;
         wdata_q   <= '0;
         acc_q     <= '0;
         rd_mask_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  st_q      <= st_d;
                  op_we_q   <= host_we;
                  wdat_en_q <= wdat_en_d;
                  wpar_en_q <= wpar_en_d;
                  row_q     <= map_row;
                  dmem_q    <= map_dmem;
                  pmem_q    <= map_pmem;
                  wdata_q   <= host_wdata;
                  rd_mask_q <= rd_mask_d;
               end
            end
            ST_RDREQ:  st_q <= ST_RDWAIT;
            ST_RDWAIT: begin
               acc_q <= fold_w;                                          // R4 / R5
               st_q  <= op_we_q ? ST_WRITE : ST_DONE;
            end
            ST_WRITE:  st_q <= ST_DONE;
            ST_DONE:   st_q <= ST_IDLE;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   for (genvar m = 0; m < NM; m++) begin : g_member
      logic is_d, is_p;
      assign is_d = (dmem_q == MW'(m));
      assign is_p = (pmem_q == MW'(m));
      assign mem_req[m] = ((st_q == ST_RDREQ) && rd_mask_q[m]) ||
                          ((st_q == ST_WRITE) && ((wdat_en_q && is_d) || (wpar_en_q && is_p)));
      assign mem_we[m]  = (st_q == ST_WRITE);
      assign mem_addr[m*AW +: AW]  = row_q;
      assign mem_wdata[m*DW +: DW] = is_p ? (acc_q ^ wdata_q) : wdata_q;
   end
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
   parameter  int NDATA = 3,
   localparam int NM    = NDATA + 1,
   localparam int MW    = $clog2(NM)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fail_en,
   input logic [MW-1:0] fail_id,
   input logic          host_ready,
   input logic          done,
   input logic [NM-1:0] mem_req,
   input logic [NM-1:0] mem_we
);
   // R8: idle controller leaves the members alone
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (mem_req == '0));

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: no new request accepted during completion
   a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !host_ready);

   // R3: reads and writes never share a cycle
   a_r3_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mem_req & mem_we)) |-> !(|(mem_req & ~mem_we)));

   // R3: at most the data and the parity member are written
   a_r3_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mem_req & mem_we) <= 2);

   // R5: a failed member is never requested
   a_r5_failed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fail_en |-> !mem_req[fail_id]);
endmodule

bind stripe_parity_ctrl psc_checker #(.NDATA(NDATA)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .fail_en    (fail_en),
   .fail_id    (fail_id),
   .host_ready (host_ready),
   .done       (done),
   .mem_req    (mem_req),
   .mem_we     (mem_we)
);

// File: tb/stripe_parity_ctrl_tb_top.sv
module stripe_parity_ctrl_tb_top;
   localparam int ND    = 3;
   localparam int DW    = 8;
   localparam int ROWS  = 4;
   localparam int NM    = ND + 1;
   localparam int AW    = $clog2(ROWS);
   localparam int MW    = $clog2(NM);
   localparam int LBN_W = $clog2(ND * ROWS);
   localparam int NBLK  = ND * ROWS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             fail_en = 1'b0;
   logic [MW-1:0]    fail_id = '0;
   logic             host_valid = 1'b0;
   logic             host_ready;
   logic             host_we = 1'b0;
   logic [LBN_W-1:0] host_lbn = '0;
   logic [DW-1:0]    host_wdata = '0;
   logic             done;
   logic [DW-1:0]    done_rdata;
   logic [NM-1:0]    mem_req, mem_we;
   logic [NM*AW-1:0] mem_addr;
   logic [NM*DW-1:0] mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   stripe_parity_ctrl #(.NDATA(ND), .DW(DW), .ROWS(ROWS)) dut_i (
      .clk, .rst_n, .fail_en, .fail_id, .host_valid, .host_ready, .host_we,
      .host_lbn, .host_wdata, .done, .done_rdata, .mem_req, .mem_we,
      .mem_addr, .mem_wdata, .mem_rdata
   );

   // member memory model and access monitor
   logic [DW-1:0] mem [NM][ROWS];
   logic [DW-1:0] rdq [NM];
   logic [AW-1:0] last_rd_addr [NM];
   int            rd_tot [NM];
   int            wr_tot [NM];
   int            ord_bad;
   logic          wrote_in_op;
   logic          rb_req = 1'b0;
   int            rb_id = 0;

   always_comb begin
      for (int m = 0; m < NM; m++) mem_rdata[m*DW +: DW] = rdq[m];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int m = 0; m < NM; m++) begin
            rdq[m] <= '0; rd_tot[m] <= 0; wr_tot[m] <= 0; last_rd_addr[m] <= '0;
            for (int s = 0; s < ROWS; s++) mem[m][s] <= '0;
         end
         ord_bad <= 0;
         wrote_in_op <= 1'b0;
      end else begin
         if (host_valid && host_ready) wrote_in_op <= 1'b0;
         else if (|(mem_req & mem_we)) wrote_in_op <= 1'b1;
         if ((|(mem_req & ~mem_we)) && wrote_in_op) ord_bad <= ord_bad + 1;
         for (int m = 0; m < NM; m++) begin
            if (mem_req[m]) begin
               if (mem_we[m]) begin
                  mem[m][mem_addr[m*AW +: AW]] <= mem_wdata[m*DW +: DW];
                  wr_tot[m] <= wr_tot[m] + 1;
               end else begin
                  rdq[m] <= mem[m][mem_addr[m*AW +: AW]];
                  rd_tot[m] <= rd_tot[m] + 1;
                  last_rd_addr[m] <= mem_addr[m*AW +: AW];
               end
            end
         end
         if (rb_req) begin
            for (int s = 0; s < ROWS; s++) begin
               logic [DW-1:0] x;
               x = '0;
               for (int o = 0; o < NM; o++) if (o != rb_id) x = x ^ mem[o][s];
               mem[rb_id][s] <= x;
            end
         end
      end
   end

   // bench bookkeeping
   int total = 0;
   int bad = 0;
   logic [DW-1:0] shadow [NBLK];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int f_pmem(input int s);
      return ND - (s % NM);
   endfunction

   function automatic int f_dmem(input int lbn);
      int k, p;
      k = lbn % ND;
      p = f_pmem(lbn / ND);
      return (k < p) ? k : k + 1;
   endfunction

   task automatic stripe_check(input bit fe, input int fid);
      bit ok = 1'b1;
      int a = 0, e = 0;
      for (int s = 0; s < ROWS; s++) begin
         logic [DW-1:0] x;
         int p;
         x = '0;
         p = f_pmem(s);
         for (int k = 0; k < ND; k++) begin
            int l, dm;
            l  = s * ND + k;
            dm = f_dmem(l);
            x  = x ^ shadow[l];
            if (!(fe && fid == dm) && mem[dm][s] !== shadow[l] && ok) begin
               ok = 1'b0; a = int'(mem[dm][s]); e = int'(shadow[l]);
            end
         end
         if (!(fe && fid == p) && mem[p][s] !== x && ok) begin
            ok = 1'b0; a = int'(mem[p][s]); e = int'(x);
         end
      end
      chk(ok, "R4", "stripe parity/data vs shadow", a, e);
   endtask

   task automatic do_op(input bit we, input int lbn, input logic [DW-1:0] wd,
                        input bit fe, input int fid);
      int s, d, p, lat, n;
      int rd0 [NM];
      int wr0 [NM];
      logic [NM-1:0] all, xrd, xwr, grd, gwr;
      int gcnt, xcnt;
      string tag;
      s = lbn / ND; d = f_dmem(lbn); p = f_pmem(s);
      all = '1;
      if (!we) begin
         lat = 3;
         if (fe && fid == d) begin xrd = all & ~(NM'(1) << fid); tag = "R5"; end
         else begin xrd = NM'(1) << d; tag = "R2"; end
         xwr = '0;
      end else if (fe && fid == p) begin
         lat = 2; xrd = '0; xwr = NM'(1) << d; tag = "R7";
      end else if (fe && fid == d) begin
         lat = 4; xrd = all & ~((NM'(1) << d) | (NM'(1) << p)); xwr = NM'(1) << p; tag = "R6";
      end else begin
         lat = 4; xrd = (NM'(1) << d) | (NM'(1) << p); xwr = xrd; tag = "R3";
      end
      for (int m = 0; m < NM; m++) begin rd0[m] = rd_tot[m]; wr0[m] = wr_tot[m]; end
      @(negedge clk);
      chk(host_ready == 1'b1, "R8", "ready before request", int'(host_ready), 1);
      host_valid = 1'b1; host_we = we; host_lbn = LBN_W'(lbn); host_wdata = wd;
      fail_en = fe; fail_id = MW'(fid);
      @(negedge clk);
      host_valid = 1'b0;
      n = 1;
      while (!done && n < 20) begin @(negedge clk); n++; end
      chk(n == lat, tag, "done latency", n, lat);
      if (!we) chk(done_rdata === shadow[lbn], tag, "read word", int'(done_rdata), int'(shadow[lbn]));
      else shadow[lbn] = wd;
      grd = '0; gwr = '0; gcnt = 0; xcnt = $countones(xrd) + $countones(xwr);
      for (int m = 0; m < NM; m++) begin
         if (rd_tot[m] != rd0[m]) grd[m] = 1'b1;
         if (wr_tot[m] != wr0[m]) gwr[m] = 1'b1;
         gcnt += (rd_tot[m] - rd0[m]) + (wr_tot[m] - wr0[m]);
      end
      chk(grd == xrd && gwr == xwr && gcnt == xcnt, tag, "member read/write masks",
          int'({gwr, grd}), int'({xwr, xrd}));
      if (tag == "R2")
         chk(int'(last_rd_addr[d]) == s, "R1", "row of member read", int'(last_rd_addr[d]), s);
      stripe_check(fe, fid);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NBLK; i++) shadow[i] = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk(host_ready == 1'b1, "R8", "reset ready", int'(host_ready), 1);
      chk(done == 1'b0, "R8", "reset done", int'(done), 0);
      chk(mem_req == '0, "R8", "reset member requests", int'(mem_req), 0);

      // R1 mapping: write a distinct word to each block, read each back
      for (int l = 0; l < NBLK; l++) do_op(1'b1, l, DW'(8'h11 * (l + 1)), 1'b0, 0);
      for (int l = 0; l < NBLK; l++) do_op(1'b0, l, '0, 1'b0, 0);

      // healthy random traffic
      for (int i = 0; i < 80; i++)
         do_op(1'($urandom % 2), int'($urandom % NBLK), DW'($urandom), 1'b0, 0);

      // each member failed in turn: directed corners then random mix
      for (int f = 0; f < NM; f++) begin
         for (int l = 0; l < NBLK; l++) begin
            if (f_dmem(l) == f) begin
               do_op(1'b1, l, DW'($urandom), 1'b1, f);   // R6 corner
               do_op(1'b0, l, '0, 1'b1, f);              // R5 readback
            end
            if (f_pmem(l / ND) == f && (l % ND) == 0)
               do_op(1'b1, l, DW'($urandom), 1'b1, f);   // R7 corner
         end
         for (int i = 0; i < 40; i++)
            do_op(1'($urandom % 2), int'($urandom % NBLK), DW'($urandom), 1'b1, f);
         @(negedge clk);
         fail_en = 1'b0; rb_id = f; rb_req = 1'b1;
         @(negedge clk);
         rb_req = 1'b0;
         for (int l = 0; l < NBLK; l++) do_op(1'b0, l, '0, 1'b0, 0);
      end

      chk(ord_bad == 0, "R3", "read issued after write in one op", ord_bad, 0);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule